// File: doc/BRIEF.md
# Two-Output Interrupt Router with Vectoring

This block gathers a set of internal and external interrupt sources and steers every one of them onto one of two processor request lines: a normal request line (`irq_o`) or a fast request line (`fiq_o`). Internal sources are synchronous level signals. Each one has a polarity bit. External pins first pass through a two-flop synchronizer. Each pin can then be used as a level input with either polarity, or as an edge input that catches rising, falling or both edges. A caught edge is held until software clears it.

Vectoring is built from programmable priority slots. There are thirty-two slots for the normal line and two for the fast line. Each slot names a source. In each cycle the block reports the lowest-numbered slot whose source is enabled, pending and routed to that slot's line. A per-line threshold hides all slots at or above a chosen number, which gives software a priority mask for nesting. Configuration and status use a plain synchronous write port and a combinational read port.

Top module: `ic_irq_fiq_ctrl`

## Requirements
- R1: After a synchronous reset, all enable, route, polarity, edge and slot registers read zero. The threshold word (address 11) reads 0x220, which means the normal threshold is 32 in bits [5:0] and the fast threshold is 2 in bits [9:8]. Both request lines and both vector-valid flags are low.
- R2: Internal source n is pending when its input differs from polarity bit n. Polarity bit 1 means active low. Polarity bits 31..0 are at address 4 and bits 63..32 are at address 5. The raw pending state, taken before the enable is applied, reads at addresses 8 (low word) and 9 (high word).
- R3: A source drives a request line only when its enable bit is 1 (address 0 for the low word, address 1 for the high word). Its route bit (address 2 low, address 3 high) selects the line: 0 means `irq_o` and 1 means `fiq_o`. A disabled source has no effect on either line or on either vector, but it still shows in the raw status.
- R4: External pin k maps to source index NUM_INT+k. In level mode, a change on the pin reaches the pending state after two rising clock edges.
- R5: Edge mode is set by bit k of address 6. A detected edge sets a pending latch three clock edges after the pin changes. Polarity 0 selects the rising edge and polarity 1 selects the falling edge. Bit k of address 7 selects both edges. The latch holds until a 1 is written to bit k of address 10. A new edge in the same cycle as the clear wins. Leaving edge mode clears the latch.
- R6: A slot at address 64+s holds a source index in bits [5:0] and a valid flag in bit 7. Slots 0..31 serve `irq_o` and slots 32..33 serve `fiq_o`. The vector output gives the lowest-numbered valid slot whose source is enabled, pending and routed to that slot's line, together with a valid flag. It is recomputed every cycle.
- R7: Only slots numbered below the threshold can be reported. Bits [5:0] of address 11 set the threshold for normal slots, and bits [9:8] set it for fast slots. The threshold does not gate `irq_o` or `fiq_o`.
- R8: Every configuration register and slot reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_src_i | input | NUM_INT | Internal level sources |
| ext_src_i | input | NUM_EXT | External asynchronous pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 7 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |
| irq_vec_o | output | 5 | Winning normal slot number |
| irq_vec_vld_o | output | 1 | Normal vector valid |
| fiq_vec_o | output | 1 | Winning fast slot number |
| fiq_vec_vld_o | output | 1 | Fast vector valid |

## Verification
Some properties are checked on every cycle: a reported slot is one that is requesting, no lower-numbered slot is requesting, a valid vector always comes with its request line raised and sits below its threshold, a set edge latch survives until it is cleared, and a pin not in edge mode never holds a latch. Other behaviours can be shown only by the bench's scenarios. These are the exact synchronizer and edge latencies, the choice of edge by polarity and both-edge mode, the routing of a source onto the fast line, the raw status staying visible for a disabled source, and the slot ordering across many source patterns.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 32;
    localparam int SRC_IDX_W = 6;

    localparam logic [ADDR_W-1:0] A_EN_LO   = 7'd0;
    localparam logic [ADDR_W-1:0] A_EN_HI   = 7'd1;
    localparam logic [ADDR_W-1:0] A_SEL_LO  = 7'd2;
    localparam logic [ADDR_W-1:0] A_SEL_HI  = 7'd3;
    localparam logic [ADDR_W-1:0] A_POL_LO  = 7'd4;
    localparam logic [ADDR_W-1:0] A_POL_HI  = 7'd5;
    localparam logic [ADDR_W-1:0] A_EDGE    = 7'd6;
    localparam logic [ADDR_W-1:0] A_BOTH    = 7'd7;
    localparam logic [ADDR_W-1:0] A_STAT_LO = 7'd8;
    localparam logic [ADDR_W-1:0] A_STAT_HI = 7'd9;
    localparam logic [ADDR_W-1:0] A_CLR     = 7'd10;
    localparam logic [ADDR_W-1:0] A_THR     = 7'd11;
    localparam int                SLOT_BASE = 64;

    typedef struct packed {
        logic                 vld;
        logic [SRC_IDX_W-1:0] src;
    } slot_t;

    function automatic logic [DATA_W-1:0] slot_word(slot_t s);
        return {24'd0, s.vld, 1'b0, s.src};
    endfunction
endpackage

// File: rtl/ic_ext_cond.sv
module ic_ext_cond #(
    parameter int NUM_EXT = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] pin_i,
    input  logic [NUM_EXT-1:0] pol_i,
    input  logic [NUM_EXT-1:0] edge_i,
    input  logic [NUM_EXT-1:0] both_i,
    input  logic [NUM_EXT-1:0] clr_i,
    output logic [NUM_EXT-1:0] pend_o
);
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_pin
        logic [2:0] sh_q;
        logic       lat_q;
        logic       rise, fall, hit;

        always_comb begin
            rise      = sh_q[1] & ~sh_q[2];
            fall      = ~sh_q[1] & sh_q[2];
            hit       = both_i[k] ? (rise | fall) : (pol_i[k] ? fall : rise);
            pend_o[k] = edge_i[k] ? lat_q : (sh_q[1] ^ pol_i[k]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q  <= '0;
                lat_q <= 1'b0;
            end else begin
                sh_q  <= {sh_q[1:0], pin_i[k]};
                lat_q <= edge_i[k] ? ((lat_q & ~clr_i[k]) | hit) : 1'b0;
            end
        end

        // R5: a caught edge is held until cleared
        p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (lat_q && !clr_i[k] && edge_i[k]) |=> lat_q);
        // R5: level mode keeps no latched edge
        p_level_nolatch_r5: assert property (@(posedge clk) disable iff (rst)
            !edge_i[k] |=> !lat_q);
    end
endmodule

// File: rtl/ic_vec_pick.sv
module ic_vec_pick #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        vld_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    // R6: reported slot is actually requesting
    p_pick_req_r6: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> req_i[idx_o]);
    // R6: no lower-numbered slot is requesting
    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
endmodule

// File: rtl/ic_irq_fiq_ctrl.sv
module ic_irq_fiq_ctrl
    import ic_pkg::*;
#(
    parameter int NUM_INT   = 36,
    parameter int NUM_EXT   = 20,
    parameter int IRQ_SLOTS = 32,
    parameter int FIQ_SLOTS = 2,
    localparam int IV_W = $clog2(IRQ_SLOTS),
    localparam int FV_W = (FIQ_SLOTS > 1) ? $clog2(FIQ_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_INT-1:0] int_src_i,
    input  logic [NUM_EXT-1:0] ext_src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [IV_W-1:0]    irq_vec_o,
    output logic               irq_vec_vld_o,
    output logic [FV_W-1:0]    fiq_vec_o,
    output logic               fiq_vec_vld_o
);
    localparam int NUM_SRC = NUM_INT + NUM_EXT;
    localparam int NSLOT   = IRQ_SLOTS + FIQ_SLOTS;
    localparam int ITHR_W  = $clog2(IRQ_SLOTS + 1);
    localparam int FTHR_W  = $clog2(FIQ_SLOTS + 1);

    logic [63:0]        en_q, sel_q, pol_q;
    logic [31:0]        edge_q, both_q;
    logic [ITHR_W-1:0]  ithr_q;
    logic [FTHR_W-1:0]  fthr_q;
    slot_t              slot_q [NSLOT];

    logic [63:0]        pend, act;
    logic [NUM_EXT-1:0] ext_pend, ext_clr;
    logic [IRQ_SLOTS-1:0] ireq;
    logic [FIQ_SLOTS-1:0] freq;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            sel_q  <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            both_q <= '0;
            ithr_q <= ITHR_W'(IRQ_SLOTS);
            fthr_q <= FTHR_W'(FIQ_SLOTS);
            for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_EN_LO:  en_q[31:0]   <= wr_data_i;
                A_EN_HI:  en_q[63:32]  <= wr_data_i;
                A_SEL_LO: sel_q[31:0]  <= wr_data_i;
                A_SEL_HI: sel_q[63:32] <= wr_data_i;
                A_POL_LO: pol_q[31:0]  <= wr_data_i;
                A_POL_HI: pol_q[63:32] <= wr_data_i;
                A_EDGE:   edge_q       <= wr_data_i;
                A_BOTH:   both_q       <= wr_data_i;
                A_THR: begin
                    ithr_q <= wr_data_i[ITHR_W-1:0];
                    fthr_q <= wr_data_i[8 +: FTHR_W];
                end
                default: ;
            endcase
            for (int s = 0; s < NSLOT; s++) begin
                if (wr_addr_i == ADDR_W'(SLOT_BASE + s))
                    slot_q[s] <= '{vld: wr_data_i[7], src: wr_data_i[SRC_IDX_W-1:0]};
            end
        end
    end

    assign ext_clr = (wr_en_i && wr_addr_i == A_CLR) ? wr_data_i[NUM_EXT-1:0] : '0;

    ic_ext_cond #(.NUM_EXT(NUM_EXT)) u_ext (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_src_i),
        .pol_i  (pol_q[NUM_SRC-1:NUM_INT]),
        .edge_i (edge_q[NUM_EXT-1:0]),
        .both_i (both_q[NUM_EXT-1:0]),
        .clr_i  (ext_clr),
        .pend_o (ext_pend)
    );

    // pending, enable and routing
    always_comb begin
        pend = '0;
        pend[NUM_INT-1:0]       = int_src_i ^ pol_q[NUM_INT-1:0];
        pend[NUM_SRC-1:NUM_INT] = ext_pend;
        act   = pend & en_q;
        irq_o = |(act & ~sel_q);
        fiq_o = |(act & sel_q);
    end

    // slot requests, gated by the priority thresholds
    for (genvar s = 0; s < IRQ_SLOTS; s++) begin : g_islot
        assign ireq[s] = slot_q[s].vld && act[slot_q[s].src] && !sel_q[slot_q[s].src]
                         && (ITHR_W'(s) < ithr_q);
    end
    for (genvar f = 0; f < FIQ_SLOTS; f++) begin : g_fslot
        assign freq[f] = slot_q[IRQ_SLOTS+f].vld && act[slot_q[IRQ_SLOTS+f].src]
                         && sel_q[slot_q[IRQ_SLOTS+f].src] && (FTHR_W'(f) < fthr_q);
    end

    ic_vec_pick #(.N(IRQ_SLOTS)) u_ipick (
        .clk(clk), .rst(rst), .req_i(ireq), .vld_o(irq_vec_vld_o), .idx_o(irq_vec_o)
    );
    ic_vec_pick #(.N(FIQ_SLOTS)) u_fpick (
        .clk(clk), .rst(rst), .req_i(freq), .vld_o(fiq_vec_vld_o), .idx_o(fiq_vec_o)
    );

    // read port
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_EN_LO:   rd_data_o = en_q[31:0];
            A_EN_HI:   rd_data_o = en_q[63:32];
            A_SEL_LO:  rd_data_o = sel_q[31:0];
            A_SEL_HI:  rd_data_o = sel_q[63:32];
            A_POL_LO:  rd_data_o = pol_q[31:0];
            A_POL_HI:  rd_data_o = pol_q[63:32];
            A_EDGE:    rd_data_o = edge_q;
            A_BOTH:    rd_data_o = both_q;
            A_STAT_LO: rd_data_o = pend[31:0];
            A_STAT_HI: rd_data_o = pend[63:32];
            A_THR: begin
                rd_data_o[ITHR_W-1:0]  = ithr_q;
                rd_data_o[8 +: FTHR_W] = fthr_q;
            end
            default: ;
        endcase
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_addr_i == ADDR_W'(SLOT_BASE + s)) rd_data_o = slot_word(slot_q[s]);
        end
    end

    // R6: a valid vector implies its request line is raised
    p_irq_vec_line_r6: assert property (@(posedge clk) disable iff (rst)
        irq_vec_vld_o |-> irq_o);
    p_fiq_vec_line_r6: assert property (@(posedge clk) disable iff (rst)
        fiq_vec_vld_o |-> fiq_o);
    // R7: a reported slot lies below its threshold
    p_irq_vec_thr_r7: assert property (@(posedge clk) disable iff (rst)
        irq_vec_vld_o |-> (ITHR_W'(irq_vec_o) < ithr_q));
    p_fiq_vec_thr_r7: assert property (@(posedge clk) disable iff (rst)
        fiq_vec_vld_o |-> (FTHR_W'(fiq_vec_o) < fthr_q));
    // R3: with nothing enabled both lines stay low
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/tb_ic_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module tb_ic_irq_fiq_ctrl;
    import ic_pkg::*;

    localparam int NUM_INT = 36;
    localparam int NUM_EXT = 20;

    logic              clk = 1'b0;
    logic              rst;
    logic [NUM_INT-1:0] int_src;
    logic [NUM_EXT-1:0] ext_src;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              irq, fiq, ivld, fvld;
    logic [4:0]        ivec;
    logic [0:0]        fvec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ic_irq_fiq_ctrl #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT)) dut (
        .clk(clk), .rst(rst), .int_src_i(int_src), .ext_src_i(ext_src),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_o(irq), .fiq_o(fiq), .irq_vec_o(ivec), .irq_vec_vld_o(ivld),
        .fiq_vec_o(fvec), .fiq_vec_vld_o(fvld)
    );

    // {pattern on sources 7..0, irq, vector valid, vector}; slot k holds source 7-k
    localparam logic [14:0] VT [8] = '{
        15'h0000, 15'h00E7, 15'h4060, 15'h40E0,
        15'h0365, 15'h0863, 15'h07E4, 15'h3061
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        int_src = '0; ext_src = '0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fiq", 32'(fiq), 0);
        chk("R1 ivld", 32'(ivld), 0);
        rd(A_THR, d);      chk("R1 thr", d, 32'h220);
        rd(A_EN_LO, d);    chk("R1 en", d, 0);
        rd(7'd64, d);      chk("R1 slot0", d, 0);

        // table setup: sources 0..7 enabled, slot k -> source 7-k
        wr(A_EN_LO, 32'hFF);
        for (int k = 0; k < 8; k++) wr(ADDR_W'(64 + k), 32'h80 | 32'(7 - k));
        rd(7'd69, d);      chk("R8 slot5 readback", d, 32'h82);

        // R6 table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            int_src = '0;
            int_src[7:0] = VT[i][14:7];
            #0.5;
            chk("R6 table irq", 32'(irq), 32'(VT[i][6]));
            chk("R6 table vld", 32'(ivld), 32'(VT[i][5]));
            if (VT[i][5]) chk("R6 table vec", 32'(ivec), 32'(VT[i][4:0]));
        end

        // R2 polarity
        int_src = '0;
        wr(A_POL_LO, 32'h8);
        rd(A_STAT_LO, d);  chk("R2 active-low pending", d, 32'h8);
        chk("R2 vec", 32'(ivec), 4);
        int_src[3] = 1'b1; #0.5;
        rd(A_STAT_LO, d);  chk("R2 active-low idle", d, 0);
        chk("R2 irq low", 32'(irq), 0);
        wr(A_POL_LO, 0);
        int_src = '0;

        // R3 routing to fast line
        wr(A_SEL_LO, 32'h1);
        wr(7'd96, 32'h80);
        int_src[0] = 1'b1; #0.5;
        chk("R3 fiq", 32'(fiq), 1);
        chk("R3 irq", 32'(irq), 0);
        chk("R6 fvld", 32'(fvld), 1);
        chk("R6 fvec", 32'(fvec), 0);
        chk("R3 irq vld excl", 32'(ivld), 0);
        wr(A_THR, 32'h020);
        chk("R7 fiq thr masks vec", 32'(fvld), 0);
        chk("R7 fiq line kept", 32'(fiq), 1);
        wr(A_THR, 32'h220);
        wr(A_EN_LO, 32'hFE);
        chk("R3 disabled fiq", 32'(fiq), 0);
        chk("R3 disabled fvld", 32'(fvld), 0);
        rd(A_STAT_LO, d);  chk("R3 raw stat kept", d, 32'h1);
        wr(A_EN_LO, 32'hFF);
        wr(A_SEL_LO, 0);
        int_src = '0;

        // R7 threshold
        int_src[7] = 1'b1; int_src[2] = 1'b1;
        wr(A_THR, 32'h203);
        chk("R7 thr3 vld", 32'(ivld), 1);
        chk("R7 thr3 vec", 32'(ivec), 0);
        wr(A_THR, 32'h200);
        chk("R7 thr0 vld", 32'(ivld), 0);
        chk("R7 thr0 line", 32'(irq), 1);
        int_src[7] = 1'b0;
        wr(A_THR, 32'h206);
        chk("R7 thr6 vec", 32'(ivec), 5);
        wr(A_THR, 32'h205);
        chk("R7 thr5 vld", 32'(ivld), 0);
        wr(A_THR, 32'h220);
        int_src = '0;

        // R4 external level (pin 0 = source 36 = high word bit 4)
        wr(A_EN_HI, 32'h10);
        @(negedge clk); ext_src[0] = 1'b1;
        step(1);  chk("R4 level after 1 edge", 32'(irq), 0);
        step(1);  chk("R4 level after 2 edges", 32'(irq), 1);
        ext_src[0] = 1'b0;
        step(2);  chk("R4 level released", 32'(irq), 0);

        // R5 rising edge
        wr(A_EDGE, 32'h1);
        rd(A_EDGE, d);     chk("R8 edge readback", d, 32'h1);
        ext_src[0] = 1'b1;
        step(2);  rd(A_STAT_HI, d); chk("R5 rise after 2", d, 0);
        step(1);  rd(A_STAT_HI, d); chk("R5 rise after 3", d, 32'h10);
        ext_src[0] = 1'b0;
        step(5);  rd(A_STAT_HI, d); chk("R5 latch held", d, 32'h10);
        wr(A_CLR, 32'h1);
        rd(A_STAT_HI, d);  chk("R5 cleared", d, 0);

        // R5 falling edge
        wr(A_POL_HI, 32'h10);
        ext_src[0] = 1'b1;
        step(4);  rd(A_STAT_HI, d); chk("R5 fall ignores rise", d, 0);
        ext_src[0] = 1'b0;
        step(3);  rd(A_STAT_HI, d); chk("R5 fall caught", d, 32'h10);
        wr(A_CLR, 32'h1);

        // R5 both edges
        wr(A_BOTH, 32'h1);
        wr(A_POL_HI, 0);
        ext_src[0] = 1'b1;
        step(3);  rd(A_STAT_HI, d); chk("R5 both rise", d, 32'h10);
        wr(A_CLR, 32'h1);
        rd(A_STAT_HI, d);  chk("R5 both cleared", d, 0);
        ext_src[0] = 1'b0;
        step(3);  rd(A_STAT_HI, d); chk("R5 both fall", d, 32'h10);
        chk("R5 irq from edge", 32'(irq), 1);

        // R5 leaving edge mode clears latch (pin low, pol 0 -> idle)
        wr(A_EDGE, 0);
        step(1);  rd(A_STAT_HI, d); chk("R5 mode exit", d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule